// File: doc/BRIEF.md
# Supply-Loss Write-Protect Sequencer

This block sits between two external supply comparators and a battery-backed static memory. It watches two digitized flags: one says the supply is above the write-protect threshold, the other says the supply is above the lower level at which the memory should run from its own supply rather than the backup cell. From these flags it drives three outputs. The first is a protect signal that the memory wrapper uses to hold the chip and write strobes inactive and its data drivers high-impedance. The second selects the backup cell as the memory's source. The third is a one-shot arming latch that keeps the backup cell disconnected from the factory until the supply first comes up properly.

Both flags pass through a synchronizer and a debounce filter before the sequencer acts on them. Protection is applied one cycle after a filtered drop of the upper flag. It is released only after the upper flag has stayed high for a programmable number of clock cycles, and a new drop during that wait restarts the wait. Switchover to the backup cell follows a drop of the lower flag while protected, but only once the arming latch is set. All timing is counted in clock cycles.

Top module: `supply_guard_seq`

## Requirements
- R1: After reset the outputs are writeProtect=1, backupSelect=0 and backupArmed=0.
- R2: While backupArmed is 0, backupSelect stays 0 whatever the lower flag does.
- R3: backupArmed becomes 1 at edge SYNC_STAGES+DEBOUNCE_CYCLES+1 after the first edge that samples the upper flag high. Once set, it stays 1 until reset, through later supply losses.
- R4: When the design is unprotected and the upper flag falls, writeProtect is still 0 at edge SYNC_STAGES+DEBOUNCE_CYCLES and is 1 at edge SYNC_STAGES+DEBOUNCE_CYCLES+1. Edges are counted from the first edge that samples the low value.
- R5: A change of either flag lasting fewer than DEBOUNCE_CYCLES clock cycles leaves every output unchanged.
- R6: After the upper flag rises, writeProtect is still 1 at edge SYNC_STAGES+DEBOUNCE_CYCLES+RECOVERY_CYCLES-1 and is 0 at edge SYNC_STAGES+DEBOUNCE_CYCLES+RECOVERY_CYCLES, counted from the first edge that samples the high value.
- R7: If the upper flag drops while that recovery wait runs, writeProtect stays 1, and the full wait of R6 restarts from the next rise.
- R8: With backupArmed=1, when both flags fall together in the unprotected state, backupSelect is 0 at edge SYNC_STAGES+DEBOUNCE_CYCLES+1 and is 1 at edge SYNC_STAGES+DEBOUNCE_CYCLES+2.
- R9: When the lower flag rises during backup, backupSelect returns to 0 at edge SYNC_STAGES+DEBOUNCE_CYCLES+1 and writeProtect stays 1.
- R10: backupSelect=1 is never seen together with writeProtect=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rstN | input | 1 | Active-low reset; restores the factory (unarmed) state |
| supplyAboveProt | input | 1 | Comparator flag, 1 = supply above write-protect threshold (asynchronous) |
| supplyAboveSwitch | input | 1 | Comparator flag, 1 = supply above backup switchover level (asynchronous) |
| writeProtect | output | 1 | 1 = memory strobes forced inactive and data outputs high-impedance |
| backupSelect | output | 1 | 1 = memory runs from the backup cell |
| backupArmed | output | 1 | 1 = backup path enabled; set at the first valid power-up |

## Verification
The hardest case to reach is a second supply drop that lands inside the recovery wait. The counter is not visible at the ports, so the stimulus raises the upper flag, waits part of the recovery window, and drops it again for longer than the debounce filter. It then raises the flag once more and checks that release comes a full recovery window after the second rise, not the first. Reaching backup switchover also needs a set-up phase: the arming latch must first be set by a complete power-up, because with the seal still intact any drop of the lower flag is ignored.

// File: rtl/supply_guard_pkg.sv
package supply_guard_pkg;

  typedef enum logic [1:0] {
    ST_SEALED    = 2'd0,
    ST_POWERED   = 2'd1,
    ST_PROTECTED = 2'd2,
    ST_BACKUP    = 2'd3
  } seqState_e;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic cntRun;
    logic cntClear;
    logic armSeal;
    logic nextWp;
    logic nextBkp;
  } seqStrobe_t;

  localparam int unsigned FLAG_PROT   = 0;
  localparam int unsigned FLAG_SWITCH = 1;
  localparam int unsigned NUM_FLAGS   = 2;

endpackage

// File: rtl/supply_flag_filter.sv
module supply_flag_filter #(
  parameter int unsigned SYNC_STAGES     = 2,
  parameter int unsigned DEBOUNCE_CYCLES = 16,
  parameter int unsigned NUM_FLAGS       = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_FLAGS-1:0] rawIn,
  output logic [NUM_FLAGS-1:0] cleanOut
);

  localparam int unsigned DW = $clog2(DEBOUNCE_CYCLES + 1);

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : gFlag
    logic [SYNC_STAGES-1:0] syncQ;
    logic [DW-1:0]          stableCnt;
    logic                   filtQ;
    logic                   syncd;

    assign syncd       = syncQ[SYNC_STAGES-1];
    assign cleanOut[g] = filtQ;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncQ     <= '0;
        stableCnt <= '0;
        filtQ     <= 1'b0;
      end else begin
        syncQ <= {syncQ[SYNC_STAGES-2:0], rawIn[g]};
        if (syncd == filtQ) begin
          stableCnt <= '0;
        end else if (stableCnt == DW'(DEBOUNCE_CYCLES - 1)) begin
          filtQ     <= syncd;
          stableCnt <= '0;
        end else begin
          stableCnt <= stableCnt + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/supply_seq_ctrl.sv
module supply_seq_ctrl
  import supply_guard_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wpOk,
  input  logic       swOk,
  input  logic       cntDone,
  input  logic       sealArmed,
  output seqStrobe_t strobe
);

  seqState_e state, nextState;

  always_comb begin
    nextState       = state;
    strobe.armSeal  = 1'b0;
    strobe.cntClear = !wpOk || (state == ST_POWERED);
    strobe.cntRun   = wpOk && (state != ST_POWERED);
    unique case (state)
      ST_SEALED: begin
        if (wpOk) begin
          strobe.armSeal = 1'b1;
          nextState      = ST_PROTECTED;
        end
      end
      ST_PROTECTED: begin
        if (wpOk && cntDone) begin
          nextState = ST_POWERED;
        end else if (!wpOk && !swOk && sealArmed) begin
          nextState = ST_BACKUP;
        end
      end
      ST_POWERED: begin
        if (!wpOk) nextState = ST_PROTECTED;
      end
      ST_BACKUP: begin
        if (swOk) nextState = ST_PROTECTED;
      end
      default: nextState = ST_SEALED;
    endcase
    strobe.nextWp  = (nextState != ST_POWERED);
    strobe.nextBkp = (nextState == ST_BACKUP);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_SEALED;
    else       state <= nextState;
  end

endmodule

// File: rtl/supply_seq_datapath.sv
module supply_seq_datapath
  import supply_guard_pkg::*;
#(
  parameter int unsigned RECOVERY_CYCLES = 4096
) (
  input  logic       clk,
  input  logic       rstN,
  input  seqStrobe_t strobe,
  output logic       cntDone,
  output logic       sealArmed,
  output logic       writeProtect,
  output logic       backupSelect
);

  localparam int unsigned CW = $clog2(RECOVERY_CYCLES);
  localparam logic [CW-1:0] CNT_LAST = CW'(RECOVERY_CYCLES - 1);

  logic [CW-1:0] recoverCnt;

  assign cntDone = (recoverCnt == CNT_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      recoverCnt <= '0;
    end else if (strobe.cntClear) begin
      recoverCnt <= '0;
    end else if (strobe.cntRun && !cntDone) begin
      recoverCnt <= recoverCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sealArmed    <= 1'b0;
      writeProtect <= 1'b1;
      backupSelect <= 1'b0;
    end else begin
      if (strobe.armSeal) sealArmed <= 1'b1;
      writeProtect <= strobe.nextWp;
      backupSelect <= strobe.nextBkp;
    end
  end

endmodule

// File: rtl/supply_guard_seq.sv
module supply_guard_seq
  import supply_guard_pkg::*;
#(
  parameter int unsigned SYNC_STAGES     = 2,
  parameter int unsigned DEBOUNCE_CYCLES = 16,
  parameter int unsigned RECOVERY_CYCLES = 4096
) (
  input  logic clk,
  input  logic rstN,
  input  logic supplyAboveProt,
  input  logic supplyAboveSwitch,
  output logic writeProtect,
  output logic backupSelect,
  output logic backupArmed
);

  logic [NUM_FLAGS-1:0] rawFlags;
  logic [NUM_FLAGS-1:0] cleanFlags;
  seqStrobe_t           strobe;
  logic                 cntDone;

  assign rawFlags[FLAG_PROT]   = supplyAboveProt;
  assign rawFlags[FLAG_SWITCH] = supplyAboveSwitch;

  supply_flag_filter #(
    .SYNC_STAGES    (SYNC_STAGES),
    .DEBOUNCE_CYCLES(DEBOUNCE_CYCLES),
    .NUM_FLAGS      (NUM_FLAGS)
  ) u_filter (
    .clk     (clk),
    .rstN    (rstN),
    .rawIn   (rawFlags),
    .cleanOut(cleanFlags)
  );

  supply_seq_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .wpOk     (cleanFlags[FLAG_PROT]),
    .swOk     (cleanFlags[FLAG_SWITCH]),
    .cntDone  (cntDone),
    .sealArmed(backupArmed),
    .strobe   (strobe)
  );

  supply_seq_datapath #(
    .RECOVERY_CYCLES(RECOVERY_CYCLES)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .cntDone     (cntDone),
    .sealArmed   (backupArmed),
    .writeProtect(writeProtect),
    .backupSelect(backupSelect)
  );

endmodule

// File: rtl/supply_guard_seq_chk.sv
module supply_guard_seq_chk (
  input logic clk,
  input logic rstN,
  input logic wpOk,
  input logic writeProtect,
  input logic backupSelect,
  input logic backupArmed
);

  AST_BACKUP_UNDER_PROTECT: assert property (@(posedge clk) disable iff (!rstN)
    backupSelect |-> writeProtect); // R10

  AST_SEAL_BLOCKS_BACKUP: assert property (@(posedge clk) disable iff (!rstN)
    !backupArmed |-> !backupSelect); // R2

  AST_ARM_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    backupArmed |=> backupArmed); // R3

  AST_DROP_PROTECTS: assert property (@(posedge clk) disable iff (!rstN)
    (!writeProtect && !wpOk) |=> writeProtect); // R4

  AST_RELEASE_NEEDS_SUPPLY: assert property (@(posedge clk) disable iff (!rstN)
    $fell(writeProtect) |-> $past(wpOk)); // R6

endmodule

bind supply_guard_seq supply_guard_seq_chk u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .wpOk        (cleanFlags[0]),
  .writeProtect(writeProtect),
  .backupSelect(backupSelect),
  .backupArmed (backupArmed)
);

// File: tb/supply_guard_seq_tb.sv
module supply_guard_seq_tb;

  localparam int S = 2;
  localparam int D = 4;
  localparam int R = 20;
  localparam int L = S + D; // filter latency in edges

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic prot = 1'b0;
  logic sw = 1'b0;
  logic writeProtect, backupSelect, backupArmed;
  int   errors = 0;
  int   checks = 0;
  bit   finished = 1'b0;

  always #10 clk = ~clk;

  supply_guard_seq #(
    .SYNC_STAGES(S), .DEBOUNCE_CYCLES(D), .RECOVERY_CYCLES(R)
  ) u_dut (
    .clk(clk), .rstN(rstN),
    .supplyAboveProt(prot), .supplyAboveSwitch(sw),
    .writeProtect(writeProtect), .backupSelect(backupSelect),
    .backupArmed(backupArmed)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b", what, act, exp);
    end
  endtask

  task automatic t_reset();
    chk(writeProtect, 1'b1, "R1 protect after reset");
    chk(backupSelect, 1'b0, "R1 backup after reset");
    chk(backupArmed, 1'b0, "R1 armed after reset");
  endtask

  task automatic t_sealed();
    sw = 1'b1; step(20);
    chk(backupSelect, 1'b0, "R2 sealed, switch high");
    sw = 1'b0; step(20);
    chk(backupSelect, 1'b0, "R2 sealed, switch low");
    chk(backupArmed, 1'b0, "R2 seal still intact");
    chk(writeProtect, 1'b1, "R2 protect while sealed");
    sw = 1'b1; step(20);
  endtask

  task automatic t_first_power();
    prot = 1'b1;
    step(L);
    chk(backupArmed, 1'b0, "R3 not yet armed");
    step(1);
    chk(backupArmed, 1'b1, "R3 armed at first power-up");
    step(R - 2);
    chk(writeProtect, 1'b1, "R6 protect held in recovery");
    step(1);
    chk(writeProtect, 1'b0, "R6 protect released");
  endtask

  task automatic t_glitch();
    prot = 1'b0; step(D - 1); prot = 1'b1;
    step(20);
    chk(writeProtect, 1'b0, "R5 short drop ignored");
    sw = 1'b0; step(D - 1); sw = 1'b1;
    step(20);
    chk(backupSelect, 1'b0, "R5 short switch drop ignored");
    chk(writeProtect, 1'b0, "R5 protect unaffected");
  endtask

  task automatic t_fail();
    prot = 1'b0;
    step(L);
    chk(writeProtect, 1'b0, "R4 not yet protected");
    step(1);
    chk(writeProtect, 1'b1, "R4 protected after drop");
    step(10);
    chk(backupSelect, 1'b0, "R8 no backup with switch flag high");
  endtask

  task automatic t_refail();
    prot = 1'b1; step(L + 8);
    prot = 1'b0; step(15);
    chk(writeProtect, 1'b1, "R7 protect held after re-drop");
    prot = 1'b1;
    step(L + R - 1);
    chk(writeProtect, 1'b1, "R7 full wait restarted");
    step(1);
    chk(writeProtect, 1'b0, "R7 release after restarted wait");
  endtask

  task automatic t_backup();
    prot = 1'b0; sw = 1'b0;
    step(L + 1);
    chk(writeProtect, 1'b1, "R8 protect first");
    chk(backupSelect, 1'b0, "R8 backup not yet");
    step(1);
    chk(backupSelect, 1'b1, "R8 backup selected");
    step(50);
    chk(backupSelect, 1'b1, "R8 backup held");
    chk(writeProtect, 1'b1, "R10 protect during backup");
    chk(backupArmed, 1'b1, "R3 armed kept through loss");
  endtask

  task automatic t_return();
    sw = 1'b1;
    step(L);
    chk(backupSelect, 1'b1, "R9 backup until filtered");
    step(1);
    chk(backupSelect, 1'b0, "R9 backup released");
    chk(writeProtect, 1'b1, "R9 protect kept");
    prot = 1'b1;
    step(L + R);
    chk(writeProtect, 1'b0, "R6 normal access after return");
    chk(backupArmed, 1'b1, "R3 armed after full cycle");
  endtask

  initial begin
    step(3);
    rstN = 1'b1;
    step(1);
    t_reset();
    t_sealed();
    t_first_power();
    t_glitch();
    t_fail();
    t_refail();
    t_backup();
    t_return();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule